// File: doc/BRIEF.md
# EEPROM Burst Configuration Loader

After reset this block reads a byte-serial configuration image from an EEPROM and turns it into 32-bit register writes. The image starts with a one-byte validity marker and a one-byte burst count. Each burst then carries a two-byte header and its data DWORDs. The header gives the starting DWORD address and the number of DWORDs. Each DWORD is stored as four bytes, most significant byte first. The loader issues one register write for each DWORD. Consecutive DWORDs in a burst go to consecutive register addresses.

Bytes arrive through a simple request/acknowledge port that carries a byte address. Before each register write the loader waits until two external busy flags are both clear: one from the switch register interface and one from the PHY management interface.

A size strap sets the highest EEPROM byte address the loader may read. If the walk would go past that address, the loader stops and raises a sticky overflow flag. When the last burst is done, the loader drops busy and raises done. A reload pulse given in the done or overflow state starts the walk again from byte 0.

Top module: `eeprom_burst_loader`

## Requirements
- R1: The byte at EEPROM address 0 must equal A5h. Any other value sends the loader straight to done, with no register writes.
- R2: The byte at address 1 is the burst count. A count of 0 ends loading with no writes. Otherwise exactly that many bursts are processed.
- R3: Each burst header is two bytes. The first byte is the DWORD address D and the second is the DWORD count N. The register byte address written is {D, 2'b00} on a 10-bit port. A count of 0 produces no writes and moves on to the next header.
- R4: Each DWORD is formed from four bytes, first byte in bits 31:24 and last byte in bits 7:0. Within a burst the DWORD address increases by 1 per write, wrapping modulo 256, so the byte address steps by 4.
- R5: `wr_en_o` is high for exactly one cycle per DWORD. It is asserted only in a cycle where `csr_busy_i` and `mii_busy_i` are both low. While either flag is high, the write waits.
- R6: `rd_req_o` stays high with a stable `rd_addr_o` until `rd_ack_i`. The byte on `rd_data_i` is taken in the acknowledge cycle. Read addresses run 0, 1, 2, … in order.
- R7: Strap value s allows byte addresses up to 128·8^s − 1 (s = 0 gives 127). No read is requested above that address. When the next read would pass it, the loader stops with `overflow_o` = 1 and `busy_o` = 0. The flag stays set until a reload.
- R8: After the last burst, `done_o` = 1 and `busy_o` = 0. At all times exactly one of `busy_o`, `done_o` and `overflow_o` is high.
- R9: A `reload_i` pulse in the done or overflow state does three things at the next edge: it clears overflow, sets busy, and restarts reading from byte 0. A reload while busy is ignored.
- R10: After reset, `busy_o` = 1, `done_o` = 0, `overflow_o` = 0, and the first read requests byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reload_i | input | 1 | Restart request, honoured only when idle |
| size_strap_i | input | STRAP_W | EEPROM size range select |
| rd_req_o | output | 1 | Byte read request |
| rd_addr_o | output | ADDR_W | EEPROM byte address |
| rd_ack_i | input | 1 | Read acknowledge; data valid this cycle |
| rd_data_i | input | 8 | Read byte |
| csr_busy_i | input | 1 | Switch register interface busy |
| mii_busy_i | input | 1 | PHY management interface busy |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | 10 | Register byte address |
| wr_data_o | output | 32 | Register write data |
| busy_o | output | 1 | Loader walking the image |
| done_o | output | 1 | Loading finished |
| overflow_o | output | 1 | Sticky EEPROM address overflow |

## Verification
A byte is consumed at the rising edge where `rd_ack_i` is high. The next request, for the following address, is visible one cycle later. The write strobe for a DWORD rises in the first cycle after its fourth byte is taken in which both busy flags are low. `done_o` or `overflow_o` appears one cycle after the final write, header or blocked address. Reload takes effect at the next edge. The bench drives everything on falling edges and samples on falling edges. Its scoreboard pops one expected address/data pair for each write strobe it sees. After the status flag rises, it checks that the queue is empty and that the write count matches.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam int          BYTE_W     = 8;
    localparam int          DWORD_W    = 32;
    localparam int          DW_AW      = 8;
    localparam int          REG_AW     = DW_AW + 2;
    localparam logic [7:0]  VALID_MARK = 8'hA5;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_WRGATE,
        ST_DONE,
        ST_OVF
    } ld_state_e;

    typedef enum logic [2:0] {
        FK_MARK,
        FK_NBURST,
        FK_HDR_HI,
        FK_HDR_LO,
        FK_DATA
    } fetch_kind_e;

    typedef struct packed {
        logic [DW_AW-1:0] dw_addr;
        logic [7:0]       dw_left;
        logic [7:0]       burst_left;
        logic [1:0]       byte_idx;
    } walk_ctx_t;

    // Highest readable byte address for a strap value: 2^(base + step*s) - 1
    function automatic logic [31:0] size_limit(input int strap, input int base_log2,
                                               input int step_log2);
        logic [31:0] one;
        one = 32'd1;
        return (one << (base_log2 + step_log2 * strap)) - one;
    endfunction

endpackage

// File: rtl/cfgld_limit.sv
module cfgld_limit
    import cfgld_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int STRAP_W   = 2,
    parameter int BASE_LOG2 = 7,
    parameter int STEP_LOG2 = 3
) (
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [ADDR_W:0]    addr_i,
    output logic               over_o
);

    localparam int PAD_W = 32 - (ADDR_W + 1);

    logic [31:0] limit;
    logic [31:0] addr_ext;

    always_comb begin
        limit    = size_limit(int'(strap_i), BASE_LOG2, STEP_LOG2);
        addr_ext = {{PAD_W{1'b0}}, addr_i};
        over_o   = addr_ext > limit;
    end

endmodule

// File: rtl/cfgld_pack.sv
module cfgld_pack
    import cfgld_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en_i,
    input  logic [BYTE_W-1:0]  byte_i,
    output logic [DWORD_W-1:0] word_o
);

    logic [DWORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (shift_en_i) begin
            word_q <= {word_q[DWORD_W-BYTE_W-1:0], byte_i};
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/cfgld_walker.sv
module cfgld_walker
    import cfgld_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reload_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              over_limit_i,
    input  logic              host_busy_i,
    output logic              rd_req_o,
    output logic [ADDR_W:0]   ee_addr_o,
    output logic              shift_en_o,
    output logic              wr_en_o,
    output logic [DW_AW-1:0]  wr_dw_addr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              overflow_o
);

    localparam logic [ADDR_W:0] ADDR_ONE = {{ADDR_W{1'b0}}, 1'b1};

    ld_state_e   state_q, state_d;
    fetch_kind_e kind_q, kind_d;
    walk_ctx_t   ctx_q, ctx_d;
    logic [ADDR_W:0] ee_addr_q, ee_addr_d;
    logic        ovf_q, ovf_d;
    logic        last_burst;

    assign last_burst = (ctx_q.burst_left == 8'd1);

    always_comb begin
        state_d   = state_q;
        kind_d    = kind_q;
        ctx_d     = ctx_q;
        ee_addr_d = ee_addr_q;
        ovf_d     = ovf_q;
        unique case (state_q)
            ST_FETCH: begin
                if (over_limit_i) begin
                    state_d = ST_OVF;
                    ovf_d   = 1'b1;
                end else if (byte_vld_i) begin
                    ee_addr_d = ee_addr_q + ADDR_ONE;
                    unique case (kind_q)
                        FK_MARK: begin
                            if (byte_i == VALID_MARK) kind_d = FK_NBURST;
                            else                      state_d = ST_DONE;
                        end
                        FK_NBURST: begin
                            ctx_d.burst_left = byte_i;
                            if (byte_i == 8'd0) state_d = ST_DONE;
                            else                kind_d  = FK_HDR_HI;
                        end
                        FK_HDR_HI: begin
                            ctx_d.dw_addr = byte_i;
                            kind_d        = FK_HDR_LO;
                        end
                        FK_HDR_LO: begin
                            ctx_d.dw_left = byte_i;
                            if (byte_i == 8'd0) begin
                                if (last_burst) begin
                                    state_d = ST_DONE;
                                end else begin
                                    ctx_d.burst_left = ctx_q.burst_left - 8'd1;
                                    kind_d           = FK_HDR_HI;
                                end
                            end else begin
                                kind_d         = FK_DATA;
                                ctx_d.byte_idx = 2'd0;
                            end
                        end
                        FK_DATA: begin
                            if (ctx_q.byte_idx == 2'd3) state_d = ST_WRGATE;
                            else ctx_d.byte_idx = ctx_q.byte_idx + 2'd1;
                        end
                        default: state_d = ST_DONE;
                    endcase
                end
            end
            ST_WRGATE: begin
                if (!host_busy_i) begin
                    ctx_d.dw_addr = ctx_q.dw_addr + 8'd1;
                    ctx_d.dw_left = ctx_q.dw_left - 8'd1;
                    if (ctx_q.dw_left == 8'd1) begin
                        if (last_burst) begin
                            state_d = ST_DONE;
                        end else begin
                            ctx_d.burst_left = ctx_q.burst_left - 8'd1;
                            state_d          = ST_FETCH;
                            kind_d           = FK_HDR_HI;
                        end
                    end else begin
                        state_d        = ST_FETCH;
                        kind_d         = FK_DATA;
                        ctx_d.byte_idx = 2'd0;
                    end
                end
            end
            ST_DONE, ST_OVF: begin
                if (reload_i) begin
                    state_d   = ST_FETCH;
                    kind_d    = FK_MARK;
                    ee_addr_d = '0;
                    ovf_d     = 1'b0;
                end
            end
            default: state_d = ST_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_FETCH;
            kind_q    <= FK_MARK;
            ctx_q     <= '0;
            ee_addr_q <= '0;
            ovf_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            kind_q    <= kind_d;
            ctx_q     <= ctx_d;
            ee_addr_q <= ee_addr_d;
            ovf_q     <= ovf_d;
        end
    end

    assign rd_req_o     = (state_q == ST_FETCH) && !over_limit_i;
    assign ee_addr_o    = ee_addr_q;
    assign shift_en_o   = (state_q == ST_FETCH) && byte_vld_i && (kind_q == FK_DATA);
    assign wr_en_o      = (state_q == ST_WRGATE) && !host_busy_i;
    assign wr_dw_addr_o = ctx_q.dw_addr;
    assign busy_o       = (state_q == ST_FETCH) || (state_q == ST_WRGATE);
    assign done_o       = (state_q == ST_DONE);
    assign overflow_o   = ovf_q;

endmodule

// File: rtl/eeprom_burst_loader.sv
module eeprom_burst_loader
    import cfgld_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int STRAP_W   = 2,
    parameter int BASE_LOG2 = 7,
    parameter int STEP_LOG2 = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reload_i,
    input  logic [STRAP_W-1:0] size_strap_i,
    output logic               rd_req_o,
    output logic [ADDR_W-1:0]  rd_addr_o,
    input  logic               rd_ack_i,
    input  logic [7:0]         rd_data_i,
    input  logic               csr_busy_i,
    input  logic               mii_busy_i,
    output logic               wr_en_o,
    output logic [9:0]         wr_addr_o,
    output logic [31:0]        wr_data_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               overflow_o
);

    logic [ADDR_W:0]    ee_addr;
    logic               over_limit;
    logic               byte_vld;
    logic               shift_en;
    logic [DW_AW-1:0]   dw_addr;
    logic               rd_req;

    assign byte_vld = rd_ack_i && rd_req;

    cfgld_limit #(
        .ADDR_W    (ADDR_W),
        .STRAP_W   (STRAP_W),
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2)
    ) u_limit (
        .strap_i (size_strap_i),
        .addr_i  (ee_addr),
        .over_o  (over_limit)
    );

    cfgld_walker #(
        .ADDR_W (ADDR_W)
    ) u_walker (
        .clk          (clk),
        .rst          (rst),
        .reload_i     (reload_i),
        .byte_vld_i   (byte_vld),
        .byte_i       (rd_data_i),
        .over_limit_i (over_limit),
        .host_busy_i  (csr_busy_i || mii_busy_i),
        .rd_req_o     (rd_req),
        .ee_addr_o    (ee_addr),
        .shift_en_o   (shift_en),
        .wr_en_o      (wr_en_o),
        .wr_dw_addr_o (dw_addr),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .overflow_o   (overflow_o)
    );

    cfgld_pack u_pack (
        .clk        (clk),
        .rst        (rst),
        .shift_en_i (shift_en),
        .byte_i     (rd_data_i),
        .word_o     (wr_data_o)
    );

    assign rd_req_o  = rd_req;
    assign rd_addr_o = ee_addr[ADDR_W-1:0];
    assign wr_addr_o = {dw_addr, 2'b00};

endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
    parameter int ADDR_W    = 16,
    parameter int STRAP_W   = 2,
    parameter int BASE_LOG2 = 7,
    parameter int STEP_LOG2 = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               reload_i,
    input logic [STRAP_W-1:0] size_strap_i,
    input logic               rd_req_o,
    input logic [ADDR_W-1:0]  rd_addr_o,
    input logic               rd_ack_i,
    input logic               csr_busy_i,
    input logic               mii_busy_i,
    input logic               wr_en_o,
    input logic               busy_o,
    input logic               done_o,
    input logic               overflow_o
);

    logic [31:0] allowed_top;
    logic [31:0] req_addr;

    always_comb begin
        allowed_top = (32'd1 << (BASE_LOG2 + STEP_LOG2 * int'(size_strap_i))) - 32'd1;
        req_addr    = 32'(rd_addr_o);
    end

    AST_WRITE_GATED: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (!csr_busy_i && !mii_busy_i)); // R5

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o))); // R6

    AST_REQ_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |-> (req_addr <= allowed_top)); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overflow_o && !reload_i) |=> overflow_o); // R7

    AST_ONE_STATUS: assert property (@(posedge clk) disable iff (rst)
        $countones({busy_o, done_o, overflow_o}) == 1); // R8

    AST_RELOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        (reload_i && !busy_o) |=> (busy_o && !overflow_o && rd_addr_o == '0)); // R9

endmodule

bind eeprom_burst_loader cfgld_checker #(
    .ADDR_W    (ADDR_W),
    .STRAP_W   (STRAP_W),
    .BASE_LOG2 (BASE_LOG2),
    .STEP_LOG2 (STEP_LOG2)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reload_i     (reload_i),
    .size_strap_i (size_strap_i),
    .rd_req_o     (rd_req_o),
    .rd_addr_o    (rd_addr_o),
    .rd_ack_i     (rd_ack_i),
    .csr_busy_i   (csr_busy_i),
    .mii_busy_i   (mii_busy_i),
    .wr_en_o      (wr_en_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .overflow_o   (overflow_o)
);

// File: tb/eeprom_burst_loader_test.sv
module eeprom_burst_loader_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        reload;
    logic [1:0]  strap;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_ack;
    logic [7:0]  rd_data;
    logic        csr_busy, mii_busy;
    logic        wr_en;
    logic [9:0]  wr_addr;
    logic [31:0] wr_data;
    logic        busy, done, ovf;

    logic [7:0]  mem [0:1023];
    logic [41:0] exp_q [$];
    int          wp;
    int          lim;
    int          checks = 0;
    int          errors = 0;
    int          wr_cnt = 0;
    int          last_rd = -1;
    int          cycles = 0;
    logic        toggle_en = 1'b0;
    logic        hold_csr = 1'b0, hold_mii = 1'b0;
    logic [2:0]  tcnt = 3'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_burst_loader uut (
        .clk (clk), .rst (rst), .reload_i (reload), .size_strap_i (strap),
        .rd_req_o (rd_req), .rd_addr_o (rd_addr), .rd_ack_i (rd_ack), .rd_data_i (rd_data),
        .csr_busy_i (csr_busy), .mii_busy_i (mii_busy),
        .wr_en_o (wr_en), .wr_addr_o (wr_addr), .wr_data_o (wr_data),
        .busy_o (busy), .done_o (done), .overflow_o (ovf)
    );

    // EEPROM model: acknowledge one cycle after a request
    always @(posedge clk) begin
        if (rst) rd_ack <= 1'b0;
        else     rd_ack <= rd_req && !rd_ack;
        tcnt <= tcnt + 3'd1;
    end
    assign rd_data  = rd_ack ? mem[rd_addr[9:0]] : 8'h00;
    assign csr_busy = toggle_en ? tcnt[1] : hold_csr;
    assign mii_busy = toggle_en ? (tcnt[2] & tcnt[0]) : hold_mii;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_ack && rd_req) begin
                check((int'(rd_addr) == last_rd + 1) || (rd_addr == 16'd0), "R6 read order",
                      64'(rd_addr), 64'(last_rd + 1));
                last_rd = int'(rd_addr);
            end
            if (rd_req && int'(rd_addr) > lim)
                check(1'b0, "R7 read above limit", 64'(rd_addr), 64'(lim));
            if (wr_en) begin
                wr_cnt++;
                check(!csr_busy && !mii_busy, "R5 write while busy flag",
                      {62'd0, csr_busy, mii_busy}, 64'd0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected write", {22'd0, wr_addr, wr_data}, 64'd0);
                end else begin
                    logic [41:0] e;
                    e = exp_q.pop_front();
                    check({wr_addr, wr_data} == e, "R3/R4 write addr/data",
                          {22'd0, wr_addr, wr_data}, {22'd0, e});
                end
            end
        end
    end

    // Global watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic clear_image();
        for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
        wp = 0;
    endtask

    task automatic put(input logic [7:0] b);
        mem[wp] = b;
        wp++;
    endtask

    // Driver: writes one burst into the image and queues its expected writes
    task automatic add_burst(input logic [7:0] dwa, input int cnt, input logic [7:0] seed);
        put(dwa);
        put(8'(cnt));
        for (int k = 0; k < cnt; k++) begin
            logic [31:0] d;
            logic [7:0]  a;
            for (int j = 0; j < 4; j++) d[31-8*j -: 8] = seed + 8'(4*k + j);
            a = dwa + 8'(k);
            if (wp + 3 <= lim) exp_q.push_back({a, 2'b00, d});
            for (int j = 0; j < 4; j++) put(d[31-8*j -: 8]);
        end
    endtask

    task automatic wait_end();
        int n;
        n = 0;
        while (!(done || ovf) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 20000) check(1'b0, "R8 loader never finished", 64'(n), 64'd0);
    endtask

    task automatic pulse_reload();
        @(negedge clk) reload = 1'b1;
        @(negedge clk) reload = 1'b0;
        check(busy && !ovf && !done, "R9 reload starts walk", {61'd0, busy, done, ovf}, 64'h4);
    endtask

    task automatic finish_check(input string req, input int base, input int n_exp);
        wait_end();
        check(done && !ovf && !busy, req, {61'd0, busy, done, ovf}, 64'h2);
        check(wr_cnt - base == n_exp, req, 64'(wr_cnt - base), 64'(n_exp));
        check(exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        int base;
        rst = 1'b1; reload = 1'b0; strap = 2'd3; lim = 65535;
        clear_image();
        put(8'hA5); put(8'd3);
        add_burst(8'h10, 1, 8'h11);
        add_burst(8'h20, 2, 8'h21);
        add_burst(8'h30, 3, 8'h31);
        toggle_en = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(busy && !done && !ovf, "R10 reset status", {61'd0, busy, done, ovf}, 64'h4);
        check(rd_req && rd_addr == 16'd0, "R10 first read at byte 0", {47'd0, rd_req, rd_addr}, 64'h10000);

        // R1 R2 R3 R4 R5: three-burst image with toggling busy flags
        finish_check("R2 three-burst image", 0, 6);
        toggle_en = 1'b0;

        // R1: bad marker
        clear_image(); put(8'h5A); put(8'd1); put(8'h00); put(8'd1);
        base = wr_cnt; pulse_reload();
        finish_check("R1 bad marker no writes", base, 0);

        // R2: zero burst count
        clear_image(); put(8'hA5); put(8'd0);
        base = wr_cnt; pulse_reload();
        finish_check("R2 zero bursts", base, 0);

        // R3 R4: zero DWORD count, DWORD address wrap
        clear_image(); put(8'hA5); put(8'd3);
        add_burst(8'h08, 0, 8'h00);
        add_burst(8'hFF, 2, 8'h40);
        add_burst(8'h09, 1, 8'h50);
        base = wr_cnt; pulse_reload();
        finish_check("R3 zero count and wrap", base, 3);

        // R5: write held while either busy flag is high
        clear_image(); put(8'hA5); put(8'd1);
        add_burst(8'h05, 1, 8'h70);
        hold_csr = 1'b1; hold_mii = 1'b0;
        base = wr_cnt; pulse_reload();
        repeat (30) @(negedge clk);
        check(wr_cnt == base && busy, "R5 stall on csr busy", 64'(wr_cnt - base), 64'd0);
        hold_csr = 1'b0; hold_mii = 1'b1;
        repeat (10) @(negedge clk);
        check(wr_cnt == base && busy, "R5 stall on mii busy", 64'(wr_cnt - base), 64'd0);
        hold_mii = 1'b0;
        finish_check("R5 write after release", base, 1);

        // R9: reload while busy is ignored
        clear_image(); put(8'hA5); put(8'd1);
        add_burst(8'h20, 8, 8'h60);
        base = wr_cnt; pulse_reload();
        repeat (12) @(negedge clk);
        reload = 1'b1; @(negedge clk); reload = 1'b0;
        finish_check("R9 reload while busy ignored", base, 8);

        // R7: overflow with smallest strap (last address 127)
        strap = 2'd0; lim = 127;
        clear_image(); put(8'hA5); put(8'd1);
        add_burst(8'h00, 64, 8'h04);
        base = wr_cnt; pulse_reload();
        wait_end();
        check(ovf && !done && !busy, "R7 overflow status", {61'd0, busy, done, ovf}, 64'h1);
        check(wr_cnt - base == 31, "R7 writes before overflow", 64'(wr_cnt - base), 64'd31);
        check(exp_q.size() == 0, "R7 queue drained", 64'(exp_q.size()), 64'd0);
        repeat (5) @(negedge clk);
        check(ovf && !rd_req, "R7 overflow sticky, no reads", {62'd0, ovf, rd_req}, 64'h2);

        // R9: reload from overflow clears the flag
        strap = 2'd3; lim = 65535;
        clear_image(); put(8'hA5); put(8'd1);
        add_burst(8'h3F, 2, 8'h90);
        base = wr_cnt; pulse_reload();
        finish_check("R9 reload after overflow", base, 2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule